// File: doc/BRIEF.md
# Multi-Input Edge Wakeup Controller

This block watches a group of external pins and turns a chosen edge on any of them into a latched event. Software picks, pin by pin, whether the pin takes part at all and whether its trigger is a rising or a falling edge. Each input is first synchronised with two flops. The synchronised value is then compared with its value one cycle earlier to find edges. A qualifying edge sets that pin's flag in the pending register. The flag stays set until software writes a 1 to its bit position.

Two outputs come from the pending register. The wakeup request goes to the power-mode logic and rises whenever any pending bit is set, whatever the interrupt enables say. With the interrupt masked, the core leaves HALT or IDLE and carries on in place. The single interrupt request is shared by all pins. It needs a port-level enable and a processor-wide enable to be set together. No separate summary pending bit exists; the OR of the per-pin flags serves that purpose.

Top module: `pin_wake_ctrl`

## Requirements
- R1: After reset the enable, edge-select and pending registers read 0, and wake_req and irq are low.
- R2: Address 0 holds the per-pin enable register and address 1 the per-pin edge-select register. Both are fully written by reg_wdata and read back unchanged on reg_rdata.
- R3: With its edge-select bit at 0, an enabled pin that goes from 0 to 1 sets its pending bit (address 2). The bit is readable on the third rising clock edge after the pin changes.
- R4: With its edge-select bit at 1, an enabled pin that goes from 1 to 0 sets its pending bit with the same latency as R3.
- R5: A pending bit is never set by an edge on a disabled pin, nor by the edge opposite to the one its edge-select bit picks.
- R6: Writing to address 2 clears each pending bit whose write-data bit is 1 and leaves the others unchanged. No other event clears a pending bit.
- R7: When a qualifying edge and a write-1-to-clear reach the same pending bit in the same cycle, the bit stays set.
- R8: wake_req is high exactly when at least one pending bit is set, whatever port_ie and global_ie are, and also after the pin's enable has been removed.
- R9: irq is high only when port_ie, global_ie and at least one pending bit are all set.
- R10: A write to address 1 sets no pending bit by itself. An edge that would be latched in the cycle right after such a write is discarded.
- R11: Address 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PINS | Asynchronous external pins |
| reg_addr | input | 2 | Register address: 0 enable, 1 edge-select, 2 pending |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | N_PINS | Register write data |
| reg_rdata | output | N_PINS | Read data for reg_addr, combinational |
| port_ie | input | 1 | Port-level interrupt enable |
| global_ie | input | 1 | Processor-wide interrupt enable |
| wake_req | output | 1 | Wakeup request to power-mode logic |
| irq | output | 1 | Shared interrupt request |

## Verification
A pin change driven between clock edges appears in the pending register, and on wake_req and irq, after the third rising edge. There are two synchroniser flops and then the pending flop. The bench therefore waits exactly three edges and samples on the following falling edge. A register write takes effect on the first rising edge and is read on the next falling edge, because reg_rdata is a plain multiplexer. The clear-collision and suppression tests depend on these counts. They line the write strobe up with the edge on which the hit would be latched, so that the outcome shows which side won.

// File: rtl/pin_wake_ctrl.sv
module pin_wake_ctrl #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [N_PINS-1:0] reg_wdata,
  output logic [N_PINS-1:0] reg_rdata,
  input  logic              port_ie,
  input  logic              global_ie,
  output logic              wake_req,
  output logic              irq
);
  localparam logic [1:0] A_EN   = 2'd0;
  localparam logic [1:0] A_SEL  = 2'd1;
  localparam logic [1:0] A_PEND = 2'd2;

  logic [N_PINS-1:0] sync1, sync2, prev;
  logic [N_PINS-1:0] en_q, sel_q, pend_q;
  logic [N_PINS-1:0] rise, fall, hit, clr;
  logic              sup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise = sync2 & ~prev;
  assign fall = ~sync2 & prev;
  assign hit  = sup_q ? '0 : (en_q & ((sel_q & fall) | (~sel_q & rise)));
  assign clr  = (reg_we && reg_addr == A_PEND) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sel_q  <= '0;
      pend_q <= '0;
      sup_q  <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_EN)  en_q  <= reg_wdata;
      if (reg_we && reg_addr == A_SEL) sel_q <= reg_wdata;
      sup_q  <= reg_we && reg_addr == A_SEL;
      pend_q <= (pend_q & ~clr) | hit;
    end
  end

  always_comb begin
    case (reg_addr)
      A_EN:    reg_rdata = en_q;
      A_SEL:   reg_rdata = sel_q;
      A_PEND:  reg_rdata = pend_q;
      default: reg_rdata = '0;
    endcase
  end

  assign wake_req = |pend_q;
  assign irq      = port_ie & global_ie & wake_req;
endmodule

// File: rtl/pin_wake_chk.sv
module pin_wake_chk #(
  parameter int N_PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_addr,
  input logic              reg_we,
  input logic              port_ie,
  input logic              global_ie,
  input logic              irq,
  input logic [N_PINS-1:0] en_q,
  input logic [N_PINS-1:0] pend_q
);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (port_ie && global_ie && (pend_q != '0)));

  // R6
  pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~pend_q) != '0) |-> $past(reg_we && reg_addr == 2'd2));

  // R5
  pend_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  // R10
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1) |-> ##2 ((pend_q & ~$past(pend_q)) == '0));
endmodule

bind pin_wake_ctrl pin_wake_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .port_ie(port_ie), .global_ie(global_ie), .irq(irq),
  .en_q(en_q), .pend_q(pend_q)
);

// File: tb/tb_pin_wake_ctrl.sv
module tb_pin_wake_ctrl;
  localparam int N = 8;
  localparam int NV = 6;
  localparam logic [N-1:0] V_EN  [NV] = '{8'hFF, 8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'hA5};
  localparam logic [N-1:0] V_SEL [NV] = '{8'h00, 8'hFF, 8'h00, 8'hF0, 8'h0F, 8'h00};
  localparam logic [N-1:0] V_PRE [NV] = '{8'h00, 8'hFF, 8'h00, 8'hF0, 8'hF0, 8'h00};
  localparam logic [N-1:0] V_POST[NV] = '{8'hFF, 8'h00, 8'hFF, 8'h0F, 8'h0F, 8'h3C};
  localparam logic [N-1:0] V_EXP [NV] = '{8'hFF, 8'hFF, 8'h0F, 8'hFF, 8'h00, 8'h24};

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin_i = '0, reg_wdata = '0, reg_rdata;
  logic [1:0] reg_addr = '0;
  logic reg_we = 0, port_ie = 0, global_ie = 0, wake_req, irq;
  int checks = 0, fails = 0;

  pin_wake_ctrl #(.N_PINS(N)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    step(2);
    rst_n = 1;
    step(1);
    rd(0, d); chk("R1 enable", d, '0);
    rd(1, d); chk("R1 select", d, '0);
    rd(2, d); chk("R1 pending", d, '0);
    chk("R1 wake", {7'b0, wake_req}, 0);
    chk("R1 irq", {7'b0, irq}, 0);

    port_ie = 1; global_ie = 1;
    for (int i = 0; i < NV; i++) begin
      wr(0, V_EN[i]);
      wr(1, V_SEL[i]);
      rd(0, d); chk("R2 enable readback", d, V_EN[i]);
      rd(1, d); chk("R2 select readback", d, V_SEL[i]);
      pin_i = V_PRE[i];
      step(4);
      wr(2, '1);
      pin_i = V_POST[i];
      step(3);
      rd(2, d); chk("R3 R4 R5 pending", d, V_EXP[i]);
      chk("R8 wake", {7'b0, wake_req}, {7'b0, V_EXP[i] != 0});
      chk("R9 irq", {7'b0, irq}, {7'b0, V_EXP[i] != 0});
    end

    wr(0, 8'hFF); wr(1, 8'h00); pin_i = '0; step(4); wr(2, '1);
    pin_i = 8'hFF; step(3);
    wr(2, 8'h0F);
    rd(2, d); chk("R6 partial clear", d, 8'hF0);

    port_ie = 0; global_ie = 0; step(1);
    chk("R8 wake with irq masked", {7'b0, wake_req}, 1);
    chk("R9 irq both off", {7'b0, irq}, 0);
    port_ie = 1; step(1);
    chk("R9 irq global off", {7'b0, irq}, 0);
    port_ie = 0; global_ie = 1; step(1);
    chk("R9 irq port off", {7'b0, irq}, 0);
    port_ie = 1; step(1);
    chk("R9 irq both on", {7'b0, irq}, 1);
    wr(0, 8'h00);
    chk("R8 wake after disable", {7'b0, wake_req}, 1);
    wr(2, '1);
    chk("R8 wake after clear", {7'b0, wake_req}, 0);

    wr(3, 8'h5A);
    rd(3, d); chk("R11 addr3 read", d, '0);
    rd(0, d); chk("R11 enable untouched", d, 8'h00);
    rd(1, d); chk("R11 select untouched", d, 8'h00);
    rd(2, d); chk("R11 pending untouched", d, 8'h00);

    pin_i = '0; wr(0, 8'h01); step(4); wr(2, '1);
    pin_i[0] = 1; step(3);
    pin_i[0] = 0; step(4);
    rd(2, d); chk("R7 setup", d, 8'h01);
    pin_i[0] = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(2, 8'h01);
    rd(2, d); chk("R7 edge beats clear", d, 8'h01);
    wr(2, '1);
    rd(2, d); chk("R7 clear alone", d, 8'h00);

    wr(1, 8'h01); step(4);
    rd(2, d); chk("R10 select write alone", d, 8'h00);
    pin_i[0] = 0;
    @(posedge clk); @(negedge clk);
    wr(1, 8'h01);
    step(3);
    rd(2, d); chk("R10 edge suppressed", d, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule